// File: doc/BRIEF.md
# Haptic motor drive control logic

This block is the digital decision core of a vibration-motor driver. It takes an external enable pin, a few decoded configuration fields and the flags from the analog comparators. From these it produces the gate commands for a differential H-bridge, a select that ties one output to the supply rail for overdrive, and an enable plus a 3-bit voltage code for the adjustable regulator that normally powers the bridge. It also passes back three status bits.

The motor spins for as long as the enable pin stays high, and both outputs sit at ground otherwise. The pin is asynchronous, so it passes through a two-flop synchronizer. Every output comes from a register, so the gate commands never glitch. The configuration fields come from a register file outside this block. That register file is not cleared by a thermal event, so once the temperature flag clears, drive resumes with the same settings.

Top module: `hap_drive_ctrl`

## Requirements
- R1: While the synchronised enable pin is low, the bridge is idle: `pos_lo`=1, `neg_lo`=1, `pos_hi`=0, `neg_hi`=0, and `reg_en`=0.
- R2: The bridge drives forward (`pos_hi`=1, `neg_lo`=1, `pos_lo`=0, `neg_hi`=0, `reg_en`=1) exactly when four conditions hold together: the pin is high, `cfg_drive_en`=1, `flag_supply_ok`=1 and `flag_overtemp`=0.
- R3: `cfg_drive_en`=0 selects power-down: the bridge is idle and `reg_en`=0, whatever the pin does.
- R4: `flag_supply_ok`=0 forces the bridge idle with `reg_en`=0.
- R5: `flag_overtemp`=1 forces the bridge idle with `reg_en`=0. After the flag clears, drive resumes with the unchanged configuration and no rewrite.
- R6: With `cfg_ovd_en`=0, both `ovd_pos_rail` and `ovd_neg_rail` are 0. With `cfg_ovd_en`=1 while driving, `cfg_ovd_pol`=0 sets `ovd_neg_rail`=1 and `cfg_ovd_pol`=1 sets `ovd_pos_rail`=1. The two are never 1 together and are both 0 when not driving.
- R7: `reg_code` follows `cfg_vcode` for the codes 000 to 110 (2.4 V to 3.6 V in 0.2 V steps). The reserved code 111 is output as 110.
- R8: `stat_supply_ok` = `flag_supply_ok`, `stat_reg_ok` = `flag_reg_ok`, and `stat_temp_ok` = NOT `flag_overtemp` (1 means protection not tripped).
- R9: In reset, and on the first cycle after it, the outputs are idle (R1 values), both rail selects are 0, `reg_code`=011 (3.0 V), and all status bits are 0.
- R10: A change on a configuration or flag input appears on the outputs after one clock edge. A change on the enable pin appears after three clock edges (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| motor_en_pin | input | 1 | Asynchronous external motor enable |
| cfg_drive_en | input | 1 | 1 = normal operation, 0 = power-down |
| cfg_ovd_en | input | 1 | 1 = allow one output on the supply rail |
| cfg_ovd_pol | input | 1 | Overdrive side: 0 = negative output, 1 = positive output |
| cfg_vcode | input | 3 | Regulator voltage code |
| flag_supply_ok | input | 1 | Supply above under-voltage threshold |
| flag_reg_ok | input | 1 | Regulator output in range |
| flag_overtemp | input | 1 | Thermal shutdown tripped |
| pos_hi | output | 1 | Positive output high-side gate |
| pos_lo | output | 1 | Positive output low-side gate |
| neg_hi | output | 1 | Negative output high-side gate |
| neg_lo | output | 1 | Negative output low-side gate |
| ovd_pos_rail | output | 1 | Tie positive output stage to supply rail |
| ovd_neg_rail | output | 1 | Tie negative output stage to supply rail |
| reg_en | output | 1 | Regulator enable |
| reg_code | output | 3 | Clamped regulator voltage code |
| stat_supply_ok | output | 1 | Status: supply valid |
| stat_reg_ok | output | 1 | Status: regulator valid |
| stat_temp_ok | output | 1 | Status: 1 = thermal protection not tripped |

## Verification
The bench sweeps every combination of the configuration and flag inputs with the pin held high, and also with the pin held low, against all eight voltage codes. This exposes a gating term that was dropped or inverted, for example a design that drives during power-down or while over temperature, or that leaves a rail select on when idle. The reserved code 111 is a targeted case, because a design without the clamp would send an out-of-range code to the regulator. Separate sequences check three further things. The pin latency must be exactly three edges, so a design that samples the pin raw or through one stage would change state early. The temperature status must be inverted. Drive must come back after a thermal event without any configuration being applied again.

// File: rtl/hap_pkg.sv
package hap_pkg;

    localparam int CODE_W     = 3;
    localparam int CODE_MAX   = 6;
    localparam int CODE_RESET = 3;

    typedef struct packed {
        logic              pos_hi;
        logic              pos_lo;
        logic              neg_hi;
        logic              neg_lo;
        logic              ovd_pos;
        logic              ovd_neg;
        logic              reg_en;
        logic [CODE_W-1:0] code;
        logic              st_sup;
        logic              st_reg;
        logic              st_temp;
    } drv_state_t;

    localparam drv_state_t DRV_RESET = '{
        pos_hi:  1'b0,
        pos_lo:  1'b1,
        neg_hi:  1'b0,
        neg_lo:  1'b1,
        ovd_pos: 1'b0,
        ovd_neg: 1'b0,
        reg_en:  1'b0,
        code:    CODE_W'(CODE_RESET),
        st_sup:  1'b0,
        st_reg:  1'b0,
        st_temp: 1'b0
    };

endpackage

// File: rtl/hap_sync.sv
module hap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hap_code_clamp.sv
module hap_code_clamp #(
    parameter int W   = 3,
    parameter int MAX = 6
) (
    input  logic [W-1:0] code_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    always_comb begin
        if (code_i > LIMIT) code_o = LIMIT;
        else                code_o = code_i;
    end
endmodule

// File: rtl/hap_drive_ctrl.sv
module hap_drive_ctrl
    import hap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              motor_en_pin,
    input  logic              cfg_drive_en,
    input  logic              cfg_ovd_en,
    input  logic              cfg_ovd_pol,
    input  logic [CODE_W-1:0] cfg_vcode,
    input  logic              flag_supply_ok,
    input  logic              flag_reg_ok,
    input  logic              flag_overtemp,
    output logic              pos_hi,
    output logic              pos_lo,
    output logic              neg_hi,
    output logic              neg_lo,
    output logic              ovd_pos_rail,
    output logic              ovd_neg_rail,
    output logic              reg_en,
    output logic [CODE_W-1:0] reg_code,
    output logic              stat_supply_ok,
    output logic              stat_reg_ok,
    output logic              stat_temp_ok
);
    logic              pin_s;
    logic [CODE_W-1:0] code_c;
    logic              allow;
    drv_state_t        st_d;
    drv_state_t        st_q;

    hap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (motor_en_pin),
        .sync_o  (pin_s)
    );

    hap_code_clamp #(.W(CODE_W), .MAX(CODE_MAX)) u_clamp (
        .code_i (cfg_vcode),
        .code_o (code_c)
    );

    always_comb begin
        st_d    = st_q;
        allow   = pin_s & cfg_drive_en & flag_supply_ok & ~flag_overtemp;
        if (allow) begin
            st_d.pos_hi = 1'b1;
            st_d.pos_lo = 1'b0;
        end else begin
            st_d.pos_hi = 1'b0;
            st_d.pos_lo = 1'b1;
        end
        st_d.neg_hi  = 1'b0;
        st_d.neg_lo  = 1'b1;
        st_d.ovd_pos = allow & cfg_ovd_en & cfg_ovd_pol;
        st_d.ovd_neg = allow & cfg_ovd_en & ~cfg_ovd_pol;
        st_d.reg_en  = allow;
        st_d.code    = code_c;
        st_d.st_sup  = flag_supply_ok;
        st_d.st_reg  = flag_reg_ok;
        st_d.st_temp = ~flag_overtemp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DRV_RESET;
        else        st_q <= st_d;
    end

    assign pos_hi         = st_q.pos_hi;
    assign pos_lo         = st_q.pos_lo;
    assign neg_hi         = st_q.neg_hi;
    assign neg_lo         = st_q.neg_lo;
    assign ovd_pos_rail   = st_q.ovd_pos;
    assign ovd_neg_rail   = st_q.ovd_neg;
    assign reg_en         = st_q.reg_en;
    assign reg_code       = st_q.code;
    assign stat_supply_ok = st_q.st_sup;
    assign stat_reg_ok    = st_q.st_reg;
    assign stat_temp_ok   = st_q.st_temp;

    // R1
    pin_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_s |=> (pos_lo && neg_lo && !pos_hi && !neg_hi && !reg_en));

    // R3
    powerdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_drive_en |=> (!reg_en && !pos_hi));

    // R5
    overtemp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overtemp |=> (!pos_hi && !reg_en && !stat_temp_ok));

    // R6
    rail_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovd_pos_rail && ovd_neg_rail));

    // R6
    rail_only_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovd_pos_rail || ovd_neg_rail) |-> pos_hi);

    // R7
    code_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_code <= CODE_W'(CODE_MAX));

    // R2
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_hi && pos_lo) && !(neg_hi && neg_lo));
endmodule

// File: tb/hap_drive_ctrl_tb_top.sv
module hap_drive_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       motor_en_pin = 1'b0;
    logic       cfg_drive_en = 1'b1;
    logic       cfg_ovd_en = 1'b0;
    logic       cfg_ovd_pol = 1'b0;
    logic [2:0] cfg_vcode = 3'd3;
    logic       flag_supply_ok = 1'b1;
    logic       flag_reg_ok = 1'b1;
    logic       flag_overtemp = 1'b0;
    logic       pos_hi, pos_lo, neg_hi, neg_lo;
    logic       ovd_pos_rail, ovd_neg_rail, reg_en;
    logic [2:0] reg_code;
    logic       stat_supply_ok, stat_reg_ok, stat_temp_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hap_drive_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .motor_en_pin(motor_en_pin),
        .cfg_drive_en(cfg_drive_en), .cfg_ovd_en(cfg_ovd_en),
        .cfg_ovd_pol(cfg_ovd_pol), .cfg_vcode(cfg_vcode),
        .flag_supply_ok(flag_supply_ok), .flag_reg_ok(flag_reg_ok),
        .flag_overtemp(flag_overtemp),
        .pos_hi(pos_hi), .pos_lo(pos_lo), .neg_hi(neg_hi), .neg_lo(neg_lo),
        .ovd_pos_rail(ovd_pos_rail), .ovd_neg_rail(ovd_neg_rail),
        .reg_en(reg_en), .reg_code(reg_code),
        .stat_supply_ok(stat_supply_ok), .stat_reg_ok(stat_reg_ok),
        .stat_temp_ok(stat_temp_ok)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // advance n edges, land on negedge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // gate word {pos_hi,pos_lo,neg_hi,neg_lo,reg_en}
    function automatic int gates_now();
        return {pos_hi, pos_lo, neg_hi, neg_lo, reg_en};
    endfunction

    localparam int DRIVE = 5'b10011;
    localparam int IDLE  = 5'b01010;

    task automatic check_all(input bit pin);
        bit run;
        int exp_rail;
        int exp_code;
        string tag;
        run = pin && cfg_drive_en && flag_supply_ok && !flag_overtemp;
        if (!pin)               tag = "R1";
        else if (!cfg_drive_en) tag = "R3";
        else if (!flag_supply_ok) tag = "R4";
        else if (flag_overtemp) tag = "R5";
        else                    tag = "R2";
        check(tag, gates_now(), run ? DRIVE : IDLE);
        exp_rail = (run && cfg_ovd_en) ? (cfg_ovd_pol ? 2 : 1) : 0;
        check("R6", {ovd_pos_rail, ovd_neg_rail}, exp_rail);
        exp_code = (cfg_vcode > 6) ? 6 : int'(cfg_vcode);
        check("R7", reg_code, exp_code);
        check("R8", {stat_supply_ok, stat_reg_ok, stat_temp_ok},
              {flag_supply_ok, flag_reg_ok, !flag_overtemp});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9 during reset
        @(negedge clk);
        check("R9", gates_now(), IDLE);
        check("R9", {ovd_pos_rail, ovd_neg_rail, reg_code}, 5'b00011);
        check("R9", {stat_supply_ok, stat_reg_ok, stat_temp_ok}, 0);
        cfg_vcode = 3'd5;
        @(negedge clk);
        rst_n = 1'b1;
        // R9: first cycle after reset still idle with pin low
        check("R9", gates_now(), IDLE);

        // R10: pin latency of three edges
        cfg_vcode = 3'd3;
        step(2);
        motor_en_pin = 1'b1;
        step(2);
        check("R10", gates_now(), IDLE);
        step(1);
        check("R10", gates_now(), DRIVE);
        motor_en_pin = 1'b0;
        step(2);
        check("R10", gates_now(), DRIVE);
        step(1);
        check("R10", gates_now(), IDLE);

        // exhaustive sweep, pin low then high
        for (int p = 0; p < 2; p++) begin
            motor_en_pin = p[0];
            step(3);
            for (int v = 0; v < 64; v++) begin
                for (int c = 0; c < 8; c++) begin
                    {cfg_drive_en, cfg_ovd_en, cfg_ovd_pol,
                     flag_supply_ok, flag_reg_ok, flag_overtemp} = v[5:0];
                    cfg_vcode = c[2:0];
                    // R10: one edge for config/flag changes
                    step(1);
                    check_all(p[0]);
                end
            end
        end

        // R5: thermal recovery keeps configuration
        motor_en_pin = 1'b1;
        cfg_drive_en = 1'b1; cfg_ovd_en = 1'b1; cfg_ovd_pol = 1'b1;
        flag_supply_ok = 1'b1; flag_overtemp = 1'b0; cfg_vcode = 3'd7;
        step(3);
        check("R5", gates_now(), DRIVE);
        flag_overtemp = 1'b1;
        step(1);
        check("R5", gates_now(), IDLE);
        check("R5", stat_temp_ok, 0);
        flag_overtemp = 1'b0;
        step(1);
        check("R5", gates_now(), DRIVE);
        check("R5", {ovd_pos_rail, ovd_neg_rail, reg_code}, 5'b10110);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule